// File: doc/BRIEF.md
# Dual-Strobe Write Qualifier

This block turns the raw control pins of an asynchronous byte-wide memory bus into clean byte-load events for a write engine. The chip-select and write-strobe pins, both active low, form the write window only while they overlap. Output enable must be inactive and a digital supply-good flag must be high during that overlap. Every pin is first brought into the fast internal clock domain through a synchroniser chain, so the window is seen as a run of consecutive clock samples.

The address is taken from the first sample of the window, which is the later of the two falling strobes. The data is taken from the last sample of the window, which is the earlier of the two rising strobes. A window shorter than a configurable number of samples is treated as a glitch and discarded. A window that is cut short by output enable going low or by supply-good dropping is abandoned. When a qualified window closes normally, the block emits a single-cycle load pulse that carries the captured address and data.

Top module: `wq_write_qual`

## Requirements
- R1: During and after reset, with no strobe activity, `load_valid_o` is 0 and `load_addr_o` and `load_data_o` are all zeros.
- R2: A window is formed only while `ce_ni`=0, `we_ni`=0, `oe_ni`=1 and `pwr_ok_i`=1. Each window that closes because a strobe returned high, having lasted at least MIN_W samples, produces exactly one `load_valid_o` pulse of one clock cycle.
- R3: `load_addr_o` carries the address present on the first sample of the window, whichever strobe fell last. Address changes later in the window are ignored.
- R4: `load_data_o` carries the data present on the last sample of the window, whichever strobe rose first. Earlier data values and values after the window are ignored.
- R5: A window of exactly MIN_W samples is accepted. A window of MIN_W-1 samples produces no event.
- R6: With `oe_ni`=0 for the whole strobe overlap, no event is produced.
- R7: With `pwr_ok_i`=0 for the whole overlap, no event is produced. If `pwr_ok_i` drops inside an already qualified window, that window produces no event.
- R8: Only one strobe low (the other high) produces no event.
- R9: If `oe_ni` goes low inside a qualified window, that window is abandoned. When `oe_ni` returns high while both strobes are still low, a new window starts and captures the address present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select pin, active low, asynchronous |
| we_ni | input | 1 | Write strobe pin, active low, asynchronous |
| oe_ni | input | 1 | Output enable pin, active low, asynchronous |
| pwr_ok_i | input | 1 | Supply-good flag, high when writes are permitted |
| addr_i | input | AW | Address bus pins |
| data_i | input | DW | Data bus pins |
| load_valid_o | output | 1 | One-cycle byte-load pulse |
| load_addr_o | output | AW | Address captured at window start |
| load_data_o | output | DW | Data captured at window end |

## Verification
The bench drives windows in which either strobe falls last and either strobe rises first. It changes the address after the window opens and the data before and after the window closes. A design that latched on the wrong edge would report the decoy address or decoy data. Window lengths of MIN_W and MIN_W-1 samples probe the glitch filter, where an off-by-one counter would either drop a legal write or pass a glitch. Inhibits are applied both for a whole window and in the middle of a qualified one, and one strobe is pulsed alone. A design that ignored inhibits, or that resumed the aborted window instead of restarting it, would emit a spurious event or carry the stale address.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [0:0] {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  // bit positions inside the synchronised control bundle
  localparam int unsigned CTL_PWR = 0;
  localparam int unsigned CTL_OE  = 1;
  localparam int unsigned CTL_WE  = 2;
  localparam int unsigned CTL_CE  = 3;
  localparam int unsigned CTL_W   = 4;
  // idle level of the pins: strobes high, supply flag low
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wq_window.sv
module wq_window
  import wq_pkg::*;
#(
  parameter int unsigned MIN_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  input  logic pwr_ok_i,
  output logic start_o,
  output logic active_o,
  output logic accept_o
);
  localparam int unsigned CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_W);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  win_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          ovl, blk, win, close_win;

  always_comb begin
    ovl       = !ce_n_i && !we_n_i;
    blk       = !oe_n_i || !pwr_ok_i;
    win       = ovl && !blk;
    start_o   = (st_q == WIN_IDLE) && win;
    active_o  = win;
    close_win = (st_q == WIN_OPEN) && !win;
    // closing by an inhibit abandons the window
    accept_o  = close_win && !blk && (cnt_q >= CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        WIN_IDLE: if (win) begin
          st_q  <= WIN_OPEN;
          cnt_q <= CNT_ONE;
        end
        WIN_OPEN: if (win) begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
        end else begin
          st_q  <= WIN_IDLE;
          cnt_q <= '0;
        end
        default: st_q <= WIN_IDLE;
      endcase
    end
  end

  // R2
  open_needs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (st_q == WIN_OPEN));
endmodule

// File: rtl/wq_capture.sv
module wq_capture #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          active_i,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          load_valid_o,
  output logic [AW-1:0] load_addr_o,
  output logic [DW-1:0] load_data_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (start_i)  addr_q <= addr_i;
      // keep the newest in-window sample; last one wins at close
      if (active_i) data_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_valid_o <= 1'b0;
      load_addr_o  <= '0;
      load_data_o  <= '0;
    end else begin
      load_valid_o <= accept_i;
      if (accept_i) begin
        load_addr_o <= addr_q;
        load_data_o <= data_q;
      end
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !start_i) |=> $stable(addr_q));

  // R4
  data_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(data_q));
endmodule

// File: rtl/wq_write_qual.sv
module wq_write_qual
  import wq_pkg::*;
#(
  parameter int unsigned AW          = 15,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_W       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          pwr_ok_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          load_valid_o,
  output logic [AW-1:0] load_addr_o,
  output logic [DW-1:0] load_data_o
);
  localparam int unsigned BW = AW + DW;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic [BW-1:0]    bus_raw, bus_s;
  logic             start, active, accept;

  assign ctl_raw = {ce_ni, we_ni, oe_ni, pwr_ok_i};
  assign bus_raw = {addr_i, data_i};

  wq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  // bus pins share the control latency so samples stay aligned
  wq_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  wq_window #(.MIN_W(MIN_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_n_i  (ctl_s[CTL_CE]),
    .we_n_i  (ctl_s[CTL_WE]),
    .oe_n_i  (ctl_s[CTL_OE]),
    .pwr_ok_i(ctl_s[CTL_PWR]),
    .start_o (start),
    .active_o(active),
    .accept_o(accept)
  );

  wq_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .active_i    (active),
    .accept_i    (accept),
    .addr_i      (bus_s[BW-1:DW]),
    .data_i      (bus_s[DW-1:0]),
    .load_valid_o(load_valid_o),
    .load_addr_o (load_addr_o),
    .load_data_o (load_data_o)
  );

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |=> !load_valid_o);

  // R8
  overlap_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> (!$past(ctl_s[CTL_CE], 2) && !$past(ctl_s[CTL_WE], 2)));

  // R6
  oe_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> ($past(ctl_s[CTL_OE], 2) && $past(ctl_s[CTL_OE], 1)));

  // R7
  pwr_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> ($past(ctl_s[CTL_PWR], 2) && $past(ctl_s[CTL_PWR], 1)));
endmodule

// File: tb/tb_wq_write_qual.sv
module tb_wq_write_qual;
  localparam int unsigned AW = 15;
  localparam int unsigned DW = 8;
  localparam int unsigned MW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          load_valid;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  int checks = 0;
  int failures = 0;
  int ev_cnt = 0;
  bit done = 1'b0;
  logic [AW+DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  wq_write_qual #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .MIN_W(MW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .pwr_ok_i(pwr_ok), .addr_i(addr), .data_i(data),
    .load_valid_o(load_valid), .load_addr_o(load_addr), .load_data_o(load_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // monitor: pops expected items as events appear
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) prev_v = 1'b0;
    else begin
      if (load_valid) begin
        logic [AW+DW-1:0] it;
        ev_cnt++;
        chk(!prev_v, "R2 pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected event", ev_cnt, ev_cnt - 1);
        else begin
          it = exp_q.pop_front();
          chk(load_addr == it[AW+DW-1:DW], "R3 address", load_addr, it[AW+DW-1:DW]);
          chk(load_data == it[DW-1:0], "R4 data", load_data, it[DW-1:0]);
        end
      end
      prev_v = load_valid;
    end
  end

  // driver: window of n samples; ce_first picks which strobe falls last
  task automatic wr(input bit ce_first, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int n, input bit exp);
    if (exp) exp_q.push_back({a, d});
    addr = ~a; data = ~d;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    step();
    addr = a;
    data = (n == 1) ? d : ~d;
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    step();
    if (n >= 2) begin
      addr = a ^ 15'h0155; data = d;
      for (int i = 0; i < n - 2; i++) step();
      step();
    end
    // the last-fallen strobe rises first
    data = d ^ 8'h5A;
    if (ce_first) we_n = 1'b1; else ce_n = 1'b1;
    step();
    ce_n = 1'b1; we_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
  endtask

  task automatic expect_events(input int n, input string tag);
    chk(ev_cnt == n, tag, ev_cnt, n);
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) step();
    // R1
    chk(load_valid == 1'b0, "R1 valid in reset", load_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk(load_valid == 1'b0 && load_addr == '0 && load_data == '0,
        "R1 outputs after reset", {load_valid, load_addr, load_data}, 0);

    // R2 R3 R4: strobe falling last differs
    wr(1'b1, 15'h5555, 8'hAA, 5, 1'b1);
    expect_events(1, "R2 we-controlled write");
    wr(1'b0, 15'h2AAA, 8'h55, 6, 1'b1);
    expect_events(2, "R2 ce-controlled write");
    wr(1'b1, 15'h7FFF, 8'h01, 4, 1'b1);
    wr(1'b0, 15'h0000, 8'hFE, 4, 1'b1);
    expect_events(4, "R2 back-to-back writes");

    // R5 boundary
    wr(1'b1, 15'h1234, 8'h3C, MW, 1'b1);
    expect_events(5, "R5 window of MIN_W accepted");
    wr(1'b0, 15'h4321, 8'hC3, MW - 1, 1'b0);
    expect_events(5, "R5 window of MIN_W-1 rejected");
    wr(1'b1, 15'h0F0F, 8'h99, 1, 1'b0);
    expect_events(5, "R5 single-sample glitch rejected");

    // R6
    oe_n = 1'b0;
    wr(1'b1, 15'h0A0A, 8'h11, 6, 1'b0);
    oe_n = 1'b1;
    expect_events(5, "R6 oe low blocks write");

    // R7
    pwr_ok = 1'b0;
    wr(1'b0, 15'h0B0B, 8'h22, 6, 1'b0);
    pwr_ok = 1'b1;
    expect_events(5, "R7 supply low blocks write");

    // R8
    ce_n = 1'b0; for (int i = 0; i < 6; i++) step(); ce_n = 1'b1;
    we_n = 1'b0; for (int i = 0; i < 6; i++) step(); we_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    expect_events(5, "R8 single strobe ignored");

    // R9: oe drops in a qualified window, then a fresh window opens
    exp_q.push_back({15'h3333, 8'h77});
    addr = 15'h1111; data = 8'h66;
    ce_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 5; i++) step();
    oe_n = 1'b0;
    for (int i = 0; i < 3; i++) step();
    addr = 15'h3333; data = 8'h77; oe_n = 1'b1;
    step();
    addr = 15'h2222;
    for (int i = 0; i < MW + 1; i++) step();
    data = 8'h00; ce_n = 1'b1;
    step();
    we_n = 1'b1;
    for (int i = 0; i < 6; i++) step();
    expect_events(6, "R9 abort then restart gives one event");

    // R7: supply drop inside a qualified window
    addr = 15'h4444; data = 8'h88;
    ce_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 5; i++) step();
    pwr_ok = 1'b0;
    step();
    ce_n = 1'b1; we_n = 1'b1;
    step();
    pwr_ok = 1'b1;
    for (int i = 0; i < 6; i++) step();
    expect_events(6, "R7 supply drop aborts qualified window");

    chk(exp_q.size() == 0, "R2 all expected events seen", exp_q.size(), 0);
    summary();
  end
endmodule